// File: doc/BRIEF.md
# PS/2 Host Register and Interrupt Unit

This block is the processor-facing side of a PS/2 host port. It presents seven 32-bit registers on a simple read/write strobe interface: global control, a data port, line control, line status, FIFO control, FIFO status and a clock divider. It holds a small receive byte FIFO and a small transmit byte FIFO. It also combines the enabled status flags into a single interrupt request.

A separate frame engine does the serial signalling on the PS/2 wires. That engine pushes received bytes into this unit and pops bytes to transmit. It reports framing faults as one-cycle error pulses, and it runs from the two clock-enable ticks that the divider produces. Software sets the divider, unmasks the flags it cares about, and then moves bytes through the data register. It clears sticky flags by writing ones to them.

Top module: `ps2rb_top`

Register offsets (byte address): 0x00 global control, 0x04 data, 0x08 line control, 0x0C line status, 0x10 FIFO control, 0x14 FIFO status, 0x18 clock divider. Registers reset to zero. FIFO status resets to 0x100 because the transmit FIFO has room.

## Requirements
- R1: After reset, the global control, line control, line status, FIFO control and divider registers read 0, FIFO status reads 0x00000100, and `irq` is low.
- R2: Bytes pushed by the frame engine are returned in arrival order in bits 7:0 of data-register reads. FIFO status bits 17:16 hold the number waiting (0 to 3), and bit 0 is high while that number is nonzero.
- R3: A push while three bytes are held drops the byte and sets FIFO status bit 1.
- R4: A data-register read with the receive FIFO empty returns 0 and sets FIFO status bit 2.
- R5: Writing 1 to a sticky flag in line status or FIFO status clears that flag only. Writing 0 leaves a flag unchanged.
- R6: `line_err` index 0 sets line status bit 0 (receive timeout), index 1 bit 1 (parity), index 2 bit 2 (acknowledge), index 3 bit 3 (stop bit), and index 4 bit 8 (transmit timeout).
- R7: A data-register write queues bits 7:0 for the frame engine. The engine sees the oldest byte on `tx_byte` while `tx_avail` is high, and takes it with `tx_pop`. FIFO status bit 8 is high while the transmit FIFO has room.
- R8: A data write while three bytes are queued drops the byte and sets FIFO status bit 9. A `tx_pop` with nothing queued sets FIFO status bit 10.
- R9: Writing 1 to FIFO control bit 16 empties the receive FIFO. Writing 1 to bit 17 empties the transmit FIFO.
- R10: `irq` is high exactly when global control bit 3 is set and some flag is set whose enable bit is set. Line flags are enabled by line control bits 0-3 and 8. FIFO flags are enabled by FIFO control bits 0-2 and 8-10. Global control bit 4 reads back `irq`.
- R11: Writing 1 to global control bit 2 sets that bit for one cycle. On the next clock edge both FIFOs empty and every sticky flag clears, while the control, enable and divider settings are kept.
- R12: With global control bit 0 set, `sample_tick` pulses once every N+1 clocks, where N is divider bits 15:8. `bit_tick` pulses on every (M+1)-th sample tick, where M is bits 7:0. A divider write restarts both counts.
- R13: `bus_en` follows global control bit 0, `host_mode` follows bit 1, and `no_ack` follows line control bit 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data port) |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| rx_push | input | 1 | Frame engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Frame engine takes the head transmit byte |
| tx_byte | output | 8 | Head of transmit FIFO (0 when empty) |
| tx_avail | output | 1 | Transmit FIFO not empty |
| line_err | input | 5 | One-cycle line fault pulses |
| bus_en | output | 1 | Port enable to the frame engine |
| host_mode | output | 1 | Host role select |
| no_ack | output | 1 | Acknowledge suppression control |
| sample_tick | output | 1 | Sampling clock enable |
| bit_tick | output | 1 | Bus-rate clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the soft reset cycle. In that cycle every kind of state must be live at once: a held receive byte, a queued transmit byte, an enabled pending line flag, and a programmed divider. Only then does the clear-versus-keep split mean anything. The stimulus builds all four through the normal ports and then writes the reset bit. The bench reads global control in the single cycle where the bit is visible, when the interrupt is still asserted. It checks again one cycle later, when the flags and FIFOs are gone but the settings remain.

// File: rtl/ps2rb_pkg.sv
// Package: register offsets and word-packing helpers shared by the
// register unit and its checker. Assumes 32-bit registers.
package ps2rb_pkg;
    localparam int OFS_GCTL = 0;
    localparam int OFS_DATA = 4;
    localparam int OFS_LCTL = 8;
    localparam int OFS_LSTS = 12;
    localparam int OFS_FCTL = 16;
    localparam int OFS_FSTS = 20;
    localparam int OFS_CDIV = 24;
    localparam int DIV_W    = 8;   // each divider field is one byte
    localparam int LINE_N   = 5;   // line fault kinds
    localparam int FIFO_N   = 6;   // FIFO flag kinds

    // Places the five line flags at their register bit positions.
    function automatic logic [31:0] line_to_word(input logic [LINE_N-1:0] f);
        logic [31:0] w;
        w      = '0;
        w[3:0] = f[3:0];
        w[8]   = f[4];
        return w;
    endfunction

    // Places the six FIFO flags (rx low half, tx high half) in the word.
    function automatic logic [31:0] fifo_to_word(input logic [FIFO_N-1:0] f);
        logic [31:0] w;
        w       = '0;
        w[2:0]  = f[2:0];
        w[10:8] = f[5:3];
        return w;
    endfunction
endpackage

// File: rtl/ps2rb_fifo.sv
// Module: ps2rb_fifo
// Small circular byte queue with occupancy count and flush.
// Assumes the caller detects overflow/underflow; an illegal push or pop
// is simply ignored here. Flush has priority over push and pop.
module ps2rb_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign dout    = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ps2rb_clkdiv.sv
// Module: ps2rb_clkdiv
// Two cascaded dividers: clock / (n+1) gives the sample tick, and the
// sample tick / (m+1) gives the bus-rate tick. Assumes restart is a
// one-cycle strobe; while run is low both counts are held at zero.
module ps2rb_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] n_div,
    input  logic [DW-1:0] m_div,
    output logic          sample_tick,
    output logic          bit_tick
);
    logic [DW-1:0] s_cnt, b_cnt;

    assign sample_tick = run & ~restart & (s_cnt == n_div);
    assign bit_tick    = sample_tick & (b_cnt == m_div);

    // Advance both stage counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            s_cnt <= '0;
            b_cnt <= '0;
        end else if (s_cnt == n_div) begin
            s_cnt <= '0;
            b_cnt <= (b_cnt == m_div) ? '0 : b_cnt + 1'b1;
        end else begin
            s_cnt <= s_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ps2rb_top.sv
// Module: ps2rb_top
// Register bank, byte FIFOs and interrupt combiner of a PS/2 host port.
// Assumes single-cycle read/write strobes, reads combinational from the
// address, a data-port read pops on the strobe edge, RX_DEPTH <= 3 so
// the fill level fits its 2-bit field.
module ps2rb_top
    import ps2rb_pkg::*;
#(
    parameter int RX_DEPTH = 3,
    parameter int TX_DEPTH = 3,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic [LINE_N-1:0] line_err,
    output logic              bus_en,
    output logic              host_mode,
    output logic              no_ack,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              irq
);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);

    logic wr_gctl, wr_data, wr_lctl, wr_lsts, wr_fctl, wr_fsts, wr_cdiv, pop_rx;
    logic gctl_en, gctl_host, gctl_ie, srst_q, lctl_noack;
    logic [LINE_N-1:0] lctl_en, line_flags, line_clr;
    logic [FIFO_N-1:0] fctl_en, fifo_sts, fifo_clr;
    logic [DIV_W-1:0]  div_n, div_m;
    logic rx_of, rx_uf, tx_of, tx_uf;
    logic flush_rx, flush_tx, irq_cond;
    logic [7:0] rx_dout, tx_dout;
    logic [RX_CW-1:0] rx_cnt;
    logic [TX_CW-1:0] tx_cnt;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [1:0] rx_lvl;
    logic unused_hi;

    assign unused_hi = ^reg_wdata[31:19];

    assign wr_gctl = reg_wr & (reg_addr == ADDR_W'(OFS_GCTL));
    assign wr_data = reg_wr & (reg_addr == ADDR_W'(OFS_DATA));
    assign wr_lctl = reg_wr & (reg_addr == ADDR_W'(OFS_LCTL));
    assign wr_lsts = reg_wr & (reg_addr == ADDR_W'(OFS_LSTS));
    assign wr_fctl = reg_wr & (reg_addr == ADDR_W'(OFS_FCTL));
    assign wr_fsts = reg_wr & (reg_addr == ADDR_W'(OFS_FSTS));
    assign wr_cdiv = reg_wr & (reg_addr == ADDR_W'(OFS_CDIV));
    assign pop_rx  = reg_rd & (reg_addr == ADDR_W'(OFS_DATA));

    assign flush_rx = srst_q | (wr_fctl & reg_wdata[16]);
    assign flush_tx = srst_q | (wr_fctl & reg_wdata[17]);
    assign line_clr = wr_lsts ? {reg_wdata[8], reg_wdata[3:0]} : '0;
    assign fifo_clr = wr_fsts ? {reg_wdata[10:8], reg_wdata[2:0]} : '0;

    ps2rb_fifo #(.DEPTH(RX_DEPTH), .W(8)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(rx_push), .din(rx_byte),
        .pop(pop_rx), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    ps2rb_fifo #(.DEPTH(TX_DEPTH), .W(8)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(wr_data), .din(reg_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    ps2rb_clkdiv #(.DW(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(gctl_en), .restart(wr_cdiv),
        .n_div(div_n), .m_div(div_m), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    // Control and enable registers; soft reset request lives one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {gctl_ie, gctl_host, gctl_en, srst_q, lctl_noack} <= '0;
            lctl_en <= '0;
            fctl_en <= '0;
            div_n   <= '0;
            div_m   <= '0;
        end else begin
            srst_q <= wr_gctl & reg_wdata[2];
            if (wr_gctl) {gctl_ie, gctl_host, gctl_en} <= {reg_wdata[3], reg_wdata[1:0]};
            if (wr_lctl) begin
                lctl_en    <= {reg_wdata[8], reg_wdata[3:0]};
                lctl_noack <= reg_wdata[18];
            end
            if (wr_fctl) fctl_en <= {reg_wdata[10:8], reg_wdata[2:0]};
            if (wr_cdiv) {div_n, div_m} <= reg_wdata[15:0];
        end
    end

    // Sticky status flags: events set, write-one clears, soft reset wipes.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            line_flags <= '0;
            {rx_of, rx_uf, tx_of, tx_uf} <= '0;
        end else begin
            line_flags <= (line_flags & ~line_clr) | line_err;
            rx_of <= (rx_of & ~fifo_clr[1]) | (rx_push & rx_full & ~pop_rx);
            rx_uf <= (rx_uf & ~fifo_clr[2]) | (pop_rx & rx_empty);
            tx_of <= (tx_of & ~fifo_clr[4]) | (wr_data & tx_full & ~tx_pop);
            tx_uf <= (tx_uf & ~fifo_clr[5]) | (tx_pop & tx_empty);
        end
    end

    assign fifo_sts = {tx_uf, tx_of, ~tx_full, rx_uf, rx_of, ~rx_empty};
    assign irq_cond = (|(line_flags & lctl_en)) | (|(fifo_sts & fctl_en));
    assign irq      = gctl_ie & irq_cond;

    assign bus_en    = gctl_en;
    assign host_mode = gctl_host;
    assign no_ack    = lctl_noack;
    assign tx_avail  = ~tx_empty;
    assign tx_byte   = tx_empty ? 8'h00 : tx_dout;
    assign rx_lvl    = (int'(rx_cnt) >= 3) ? 2'd3 : 2'(rx_cnt);

    // Read-data selection by address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_GCTL): reg_rdata = {27'd0, irq, gctl_ie, srst_q, gctl_host, gctl_en};
            ADDR_W'(OFS_DATA): reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
            ADDR_W'(OFS_LCTL): reg_rdata = line_to_word(lctl_en) | {13'd0, lctl_noack, 18'd0};
            ADDR_W'(OFS_LSTS): reg_rdata = line_to_word(line_flags);
            ADDR_W'(OFS_FCTL): reg_rdata = fifo_to_word(fctl_en);
            ADDR_W'(OFS_FSTS): reg_rdata = fifo_to_word(fifo_sts) | {14'd0, rx_lvl, 16'd0};
            ADDR_W'(OFS_CDIV): reg_rdata = {16'd0, div_n, div_m};
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ps2rb_chk.sv
// Module: ps2rb_chk
// Property checker for ps2rb_top, attached by bind. Observes only.
module ps2rb_chk #(
    parameter int RX_DEPTH = 3,
    parameter int TX_DEPTH = 3,
    localparam int RX_CW = $clog2(RX_DEPTH + 1),
    localparam int TX_CW = $clog2(TX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             pop_rx,
    input logic             flush_rx,
    input logic [RX_CW-1:0] rx_cnt,
    input logic             rx_of,
    input logic             wr_data,
    input logic             tx_pop,
    input logic             flush_tx,
    input logic [TX_CW-1:0] tx_cnt,
    input logic             tx_of,
    input logic             wr_gctl,
    input logic             srst_q,
    input logic [4:0]       line_flags,
    input logic             gctl_ie,
    input logic             gctl_en,
    input logic             irq,
    input logic             sample_tick,
    input logic             bit_tick
);
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= RX_DEPTH);
    a_r3_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && int'(rx_cnt) == RX_DEPTH && !pop_rx && !flush_rx |=> rx_of);
    a_r8_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && int'(tx_cnt) == TX_DEPTH && !tx_pop && !flush_tx |=> tx_of);
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gctl_ie);
    a_r11_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q && !wr_gctl |=> !srst_q);
    a_r11_srst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (rx_cnt == '0 && tx_cnt == '0 && line_flags == '0));
    a_r12_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    a_r12_tick_run: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> gctl_en);
endmodule

bind ps2rb_top ps2rb_chk #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .pop_rx(pop_rx), .flush_rx(flush_rx),
    .rx_cnt(rx_cnt), .rx_of(rx_of), .wr_data(wr_data), .tx_pop(tx_pop),
    .flush_tx(flush_tx), .tx_cnt(tx_cnt), .tx_of(tx_of), .wr_gctl(wr_gctl),
    .srst_q(srst_q), .line_flags(line_flags), .gctl_ie(gctl_ie), .gctl_en(gctl_en),
    .irq(irq), .sample_tick(sample_tick), .bit_tick(bit_tick)
);

// File: tb/ps2rb_top_tb_top.sv
// Scoreboard bench for ps2rb_top: drivers queue expected bytes, the
// take tasks act as monitors that pop and compare the design's output.
module ps2rb_top_tb_top;
    localparam int A_GCTL = 0, A_DATA = 4, A_LCTL = 8, A_LSTS = 12;
    localparam int A_FCTL = 16, A_FSTS = 20, A_CDIV = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, rx_push = 0, tx_pop = 0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [7:0] rx_byte = '0, tx_byte;
    logic [4:0] line_err = '0;
    logic tx_avail, bus_en, host_mode, no_ack, sample_tick, bit_tick, irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];

    always #4 clk = ~clk;

    ps2rb_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_push(rx_push), .rx_byte(rx_byte),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail), .line_err(line_err),
        .bus_en(bus_en), .host_mode(host_mode), .no_ack(no_ack),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic bread(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = 5'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rcheck(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        bread(a, v);
        check(req, v, exp);
    endtask

    // Driver: frame engine delivers a byte; scoreboard keeps it if room.
    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1; rx_byte = b;
        if (rx_q.size() < 3) rx_q.push_back(b);
        @(negedge clk);
        rx_push = 0;
    endtask

    // Monitor: data-port read compared with scoreboard head (0 if empty).
    task automatic rx_take(input string req);
        logic [31:0] v;
        logic [7:0] e;
        e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'h00;
        bread(A_DATA, v);
        check(req, v, {24'd0, e});
    endtask

    task automatic tx_send(input logic [7:0] b);
        if (tx_q.size() < 3) tx_q.push_back(b);
        bwrite(A_DATA, {24'd0, b});
    endtask

    // Monitor: engine side sees scoreboard head then takes it.
    task automatic tx_take(input string req);
        logic [7:0] e;
        e = tx_q.pop_front();
        @(negedge clk);
        check(req, {31'd0, tx_avail}, 32'd1);
        check(req, {24'd0, tx_byte}, {24'd0, e});
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic err_pulse(input int idx);
        @(negedge clk);
        line_err = 5'(1 << idx);
        @(negedge clk);
        line_err = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int s_cnt, b_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rcheck("R1 gctl", A_GCTL, 32'h0);
        rcheck("R1 lctl", A_LCTL, 32'h0);
        rcheck("R1 lsts", A_LSTS, 32'h0);
        rcheck("R1 fctl", A_FCTL, 32'h0);
        rcheck("R1 fsts", A_FSTS, 32'h100);
        rcheck("R1 cdiv", A_CDIV, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R13 control outputs
        bwrite(A_GCTL, 32'h3);
        check("R13 bus_en", {31'd0, bus_en}, 32'd1);
        check("R13 host_mode", {31'd0, host_mode}, 32'd1);
        bwrite(A_LCTL, 32'h40000);
        check("R13 no_ack", {31'd0, no_ack}, 32'd1);
        rcheck("R13 lctl readback", A_LCTL, 32'h40000);
        bwrite(A_LCTL, 32'h0);

        // R2 ordering and level
        rx_send(8'h5A); rx_send(8'hC3);
        rcheck("R2 level two", A_FSTS, 32'h20101);
        rx_take("R2 first byte"); rx_take("R2 second byte");
        rcheck("R2 drained", A_FSTS, 32'h100);

        // R3 overflow
        rx_send(8'h11); rx_send(8'h22); rx_send(8'h33); rx_send(8'h44);
        rcheck("R3 full and overflow", A_FSTS, 32'h30103);
        rx_take("R3 kept 1"); rx_take("R3 kept 2"); rx_take("R3 kept 3");

        // R4 underflow
        rx_take("R4 empty read zero");
        rcheck("R4 underflow flag", A_FSTS, 32'h106);

        // R5 write-one-to-clear, FIFO side
        bwrite(A_FSTS, 32'h2);
        rcheck("R5 clear overflow only", A_FSTS, 32'h104);
        bwrite(A_FSTS, 32'h4);
        rcheck("R5 clear underflow", A_FSTS, 32'h100);

        // R6 line flags
        err_pulse(0); rcheck("R6 rx timeout", A_LSTS, 32'h1);
        err_pulse(1); rcheck("R6 parity", A_LSTS, 32'h3);
        err_pulse(2); rcheck("R6 ack", A_LSTS, 32'h7);
        err_pulse(3); rcheck("R6 stop", A_LSTS, 32'hF);
        err_pulse(4); rcheck("R6 tx timeout", A_LSTS, 32'h10F);
        bwrite(A_LSTS, 32'h0A);
        rcheck("R5 line partial clear", A_LSTS, 32'h105);
        bwrite(A_LSTS, 32'h105);
        rcheck("R5 line all clear", A_LSTS, 32'h0);

        // R7 transmit path, R8 overflow/underflow
        tx_send(8'hA1); tx_send(8'hA2); tx_send(8'hA3);
        rcheck("R7 tx full no ready", A_FSTS, 32'h0);
        tx_send(8'hA4);
        rcheck("R8 tx overflow", A_FSTS, 32'h200);
        tx_take("R7 tx 1"); tx_take("R7 tx 2"); tx_take("R7 tx 3");
        @(negedge clk);
        check("R8 dropped byte absent", {31'd0, tx_avail}, 32'd0);
        tx_pop = 1; @(negedge clk); tx_pop = 0;
        rcheck("R8 tx underflow", A_FSTS, 32'h700);
        bwrite(A_FSTS, 32'h600);
        rcheck("R5 tx flags cleared", A_FSTS, 32'h100);

        // R9 flushes
        rx_send(8'h01); rx_send(8'h02);
        bwrite(A_FCTL, 32'h10000);
        rx_q.delete();
        rcheck("R9 rx flushed", A_FSTS, 32'h100);
        tx_send(8'hB1); tx_send(8'hB2);
        bwrite(A_FCTL, 32'h20000);
        tx_q.delete();
        check("R9 tx flushed", {31'd0, tx_avail}, 32'd0);

        // R10 interrupt combining
        bwrite(A_LCTL, 32'h2);
        err_pulse(1);
        check("R10 masked by global", {31'd0, irq}, 32'd0);
        rcheck("R10 flag bit low", A_GCTL, 32'h3);
        bwrite(A_GCTL, 32'hB);
        check("R10 irq high", {31'd0, irq}, 32'd1);
        rcheck("R10 flag mirrors", A_GCTL, 32'h1B);
        bwrite(A_LCTL, 32'h0);
        check("R10 source disabled", {31'd0, irq}, 32'd0);
        bwrite(A_LSTS, 32'h2);
        bwrite(A_FCTL, 32'h1);
        rx_send(8'h77);
        check("R10 rx ready irq", {31'd0, irq}, 32'd1);
        rx_take("R10 rx byte");
        check("R10 irq after drain", {31'd0, irq}, 32'd0);
        bwrite(A_FCTL, 32'h0);

        // R12 divider
        bwrite(A_CDIV, 32'h0301);
        rcheck("R12 divider readback", A_CDIV, 32'h301);
        s_cnt = 0; b_cnt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            s_cnt += int'(sample_tick);
            b_cnt += int'(bit_tick);
        end
        check("R12 sample ticks", 32'(s_cnt), 32'd16);
        check("R12 bit ticks", 32'(b_cnt), 32'd8);

        // R11 soft reset
        bwrite(A_LCTL, 32'h2);
        err_pulse(1);
        rx_send(8'h99);
        tx_send(8'h55);
        bwrite(A_GCTL, 32'hF);
        reg_addr = 5'(A_GCTL);
        #1 check("R11 bit visible one cycle", reg_rdata, 32'h1F);
        rx_q.delete(); tx_q.delete();
        rcheck("R11 bit self-cleared", A_GCTL, 32'hB);
        rcheck("R11 fifo state cleared", A_FSTS, 32'h100);
        rcheck("R11 line flags cleared", A_LSTS, 32'h0);
        rcheck("R11 divider kept", A_CDIV, 32'h301);
        rcheck("R11 enables kept", A_LCTL, 32'h2);
        check("R11 tx emptied", {31'd0, tx_avail}, 32'd0);

        finish_run();
    end
endmodule